// File: doc/BRIEF.md
# Transmit Message Selector

This block decides which message box a CAN controller sends next. Each box holds an identifier in standard (11-bit) or extended (29-bit) form and a transmit-request flag. The host writes the flag and the identifiers. Among the boxes that are enabled by a box-count register and that have a request pending, the selector offers the one with the highest bus priority. Bus priority means the smallest identifier when identifiers are compared from the most significant bit.

The frame engine pulses `start_i` to take the offered box. That box stays locked for the whole frame. The engine then reports success or failure. On success the box's request is cleared and its number is latched for the host to read. On an error or a lost arbitration the request stays pending, and the box competes again.

Top module: `tx_sel_top`

## Requirements
- R1: After reset no request is pending, `sel_valid_o`, `busy_o` and `last_box_o` are 0, and the box count is 0.
- R2: A box takes part only when its index is below the count written through `cnt_we_i`/`cnt_i`. The offer changes in the cycle after the count is written.
- R3: The winner has the numerically lowest 30-bit key. An extended identifier fills key bits 29:1. A standard identifier (low 11 bits of `cfg_id_i`) fills key bits 29:19, and bits 18:1 are zero. Key bit 0 is `cfg_ext_i`.
- R4: When a standard and an extended identifier are equal in their common prefix and the rest of the extended identifier is zero, the standard box wins.
- R5: When two keys are equal, the lower box number wins.
- R6: A `start_i` pulse while a box is offered and no frame is active sets `busy_o` and locks `sel_box_o`. The locked value holds until completion, whatever other requests arrive.
- R7: `done_ok_i` during a frame clears the locked box's request, copies its number to `last_box_o` and clears `busy_o`. If both completion inputs arrive in the same cycle, `done_ok_i` takes effect.
- R8: `done_err_i` during a frame clears `busy_o` and leaves the request set, so the box is offered again.
- R9: An identifier write that targets the box locked for the current frame is ignored. Writes to other boxes take effect.
- R10: `req_o` shows each box's request flag (bit i for box i). A `req_set_i` pulse sets the flag of box `req_box_i` one cycle later.
- R11: `start_i` with nothing offered, and completion pulses with no frame active, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write the identifier of box `cfg_box_i` |
| cfg_box_i | input | 4 | Box to configure |
| cfg_id_i | input | 29 | Identifier (low 11 bits used when standard) |
| cfg_ext_i | input | 1 | 1 = extended format |
| req_set_i | input | 1 | Set the request flag of `req_box_i` |
| req_box_i | input | 4 | Box whose request is set |
| cnt_we_i | input | 1 | Write the box count |
| cnt_i | input | 5 | Number of boxes that take part |
| start_i | input | 1 | Frame engine takes the offered box |
| done_ok_i | input | 1 | Frame finished successfully |
| done_err_i | input | 1 | Frame failed or arbitration lost |
| sel_valid_o | output | 1 | A box is offered or locked |
| sel_box_o | output | 4 | Offered or locked box |
| busy_o | output | 1 | Frame in progress |
| last_box_o | output | 4 | Box of the last successful frame |
| req_o | output | 16 | Request flags |

## Verification
The hardest case to set up is a write to the identifier of the box that is locked for the current frame. A wrong design would accept the write silently, and nothing changes until the box competes again. The stimulus locks one box, rewrites its identifier to a winning value, and ends the frame with an error. It then raises a competitor whose identifier lies between the old and the new value. The box that is offered next shows which identifier was kept. A second point needs care: a new request of higher priority that arrives during a frame must not move the lock.

// File: rtl/tx_sel_pkg.sv
package tx_sel_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int KEY_W = ID_W + 1;

  // key = {aligned id, ext}; smaller key = higher bus priority
  function automatic logic [KEY_W-1:0] make_key(logic [ID_W-1:0] id, logic ext);
    logic [ID_W-1:0] al;
    al = ext ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
    return {al, ext};
  endfunction
endpackage

// File: rtl/tx_sel_store.sv
module tx_sel_store
  import tx_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int BW = 4,
  parameter int CW = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [BW-1:0]             cfg_box_i,
  input  logic [ID_W-1:0]           cfg_id_i,
  input  logic                      cfg_ext_i,
  input  logic                      req_set_i,
  input  logic [BW-1:0]             req_box_i,
  input  logic                      cnt_we_i,
  input  logic [CW-1:0]             cnt_i,
  input  logic                      busy_i,
  input  logic [BW-1:0]             lock_box_i,
  input  logic                      clr_i,
  output logic [N-1:0][KEY_W-1:0]   keys_o,
  output logic [N-1:0]              elig_o,
  output logic [N-1:0]              req_o,
  output logic [CW-1:0]             cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          cfg_ok;

  assign cfg_ok = cfg_we_i && !(busy_i && cfg_box_i == lock_box_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_i;
  end
  assign cnt_o = cnt_q;

  for (genvar g = 0; g < N; g++) begin : g_box
    logic [KEY_W-1:0] key_q;
    logic             req_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '1;
        req_q <= 1'b0;
      end else begin
        if (cfg_ok && cfg_box_i == BW'(g))
          key_q <= make_key(cfg_id_i, cfg_ext_i);
        if (req_set_i && req_box_i == BW'(g))
          req_q <= 1'b1;
        else if (clr_i && lock_box_i == BW'(g))
          req_q <= 1'b0;
      end
    end

    assign keys_o[g] = key_q;
    assign req_o[g]  = req_q;
    assign elig_o[g] = req_q && (CW'(g) < cnt_q);
  end
endmodule

// File: rtl/tx_sel_tree.sv
module tx_sel_tree
  import tx_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int BW = 4
) (
  input  logic [N-1:0][KEY_W-1:0] keys_i,
  input  logic [N-1:0]            elig_i,
  output logic                    win_valid_o,
  output logic [BW-1:0]           win_box_o
);
  // heap layout: node k has children 2k and 2k+1, leaves at N..2N-1
  logic [2*N-1:1]              nv;
  logic [2*N-1:1][KEY_W-1:0]   nk;
  logic [2*N-1:1][BW-1:0]      ni;

  for (genvar g = 0; g < N; g++) begin : g_leaf
    assign nv[N+g] = elig_i[g];
    assign nk[N+g] = keys_i[g];
    assign ni[N+g] = BW'(g);
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    logic take_r;
    // right child only on strictly smaller key: ties keep lower box
    assign take_r = nv[2*k+1] && (!nv[2*k] || nk[2*k+1] < nk[2*k]);
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign nk[k]  = take_r ? nk[2*k+1] : nk[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  assign win_valid_o = nv[1];
  assign win_box_o   = ni[1];
endmodule

// File: rtl/tx_sel_ctrl.sv
module tx_sel_ctrl #(
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_ok_i,
  input  logic          done_err_i,
  input  logic          win_valid_i,
  input  logic [BW-1:0] win_box_i,
  output logic          busy_o,
  output logic [BW-1:0] lock_box_o,
  output logic          clr_o,
  output logic [BW-1:0] last_box_o
);
  logic          busy_q;
  logic [BW-1:0] lock_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lock_q <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start_i && win_valid_i) begin
        busy_q <= 1'b1;
        lock_q <= win_box_i;
      end
    end else if (done_ok_i) begin
      busy_q <= 1'b0;
      last_q <= lock_q;
    end else if (done_err_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign lock_box_o = lock_q;
  assign clr_o      = busy_q && done_ok_i;
  assign last_box_o = last_q;
endmodule

// File: rtl/tx_sel_top.sv
module tx_sel_top
  import tx_sel_pkg::*;
#(
  parameter int N  = 16,
  localparam int BW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [BW-1:0]   cfg_box_i,
  input  logic [ID_W-1:0] cfg_id_i,
  input  logic            cfg_ext_i,
  input  logic            req_set_i,
  input  logic [BW-1:0]   req_box_i,
  input  logic            cnt_we_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            start_i,
  input  logic            done_ok_i,
  input  logic            done_err_i,
  output logic            sel_valid_o,
  output logic [BW-1:0]   sel_box_o,
  output logic            busy_o,
  output logic [BW-1:0]   last_box_o,
  output logic [N-1:0]    req_o
);
  logic [N-1:0][KEY_W-1:0] keys;
  logic [N-1:0]            elig;
  logic [CW-1:0]           cnt_q;
  logic                    win_valid, busy, clr;
  logic [BW-1:0]           win_box, lock_box;

  tx_sel_store #(.N(N), .BW(BW), .CW(CW)) u_store (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_box_i, .cfg_id_i, .cfg_ext_i,
    .req_set_i, .req_box_i, .cnt_we_i, .cnt_i,
    .busy_i(busy), .lock_box_i(lock_box), .clr_i(clr),
    .keys_o(keys), .elig_o(elig), .req_o(req_o), .cnt_o(cnt_q)
  );

  tx_sel_tree #(.N(N), .BW(BW)) u_tree (
    .keys_i(keys), .elig_i(elig),
    .win_valid_o(win_valid), .win_box_o(win_box)
  );

  tx_sel_ctrl #(.BW(BW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .done_ok_i, .done_err_i,
    .win_valid_i(win_valid), .win_box_i(win_box),
    .busy_o(busy), .lock_box_o(lock_box), .clr_o(clr), .last_box_o(last_box_o)
  );

  assign busy_o      = busy;
  assign sel_valid_o = busy | win_valid;
  assign sel_box_o   = busy ? lock_box : win_box;
endmodule

// File: rtl/tx_sel_chk.sv
module tx_sel_chk #(
  parameter int N  = 16,
  parameter int BW = 4,
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_set_i,
  input logic [BW-1:0] req_box_i,
  input logic          start_i,
  input logic          done_ok_i,
  input logic          done_err_i,
  input logic          sel_valid_o,
  input logic [BW-1:0] sel_box_o,
  input logic          busy_o,
  input logic [BW-1:0] last_box_o,
  input logic [N-1:0]  req_o,
  input logic [CW-1:0] cnt_q
);
  assert_offer_eligible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && !busy_o) |-> (req_o[sel_box_o] && CW'(sel_box_o) < cnt_q));

  assert_lock_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_ok_i && !done_err_i) |=> (busy_o && sel_box_o == $past(sel_box_o)));

  assert_ok_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_ok_i && !(req_set_i && req_box_i == sel_box_o))
      |=> (!busy_o && !req_o[$past(sel_box_o)] && last_box_o == $past(sel_box_o)));

  assert_err_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_err_i && !done_ok_i) |=> (!busy_o && req_o[$past(sel_box_o)]));

  assert_idle_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sel_valid_o && start_i) |=> !busy_o);

  assert_idle_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (done_ok_i || done_err_i)) |=> $stable(last_box_o));
endmodule

bind tx_sel_top tx_sel_chk #(.N(N), .BW(BW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_set_i(req_set_i), .req_box_i(req_box_i),
  .start_i(start_i), .done_ok_i(done_ok_i), .done_err_i(done_err_i),
  .sel_valid_o(sel_valid_o), .sel_box_o(sel_box_o), .busy_o(busy_o),
  .last_box_o(last_box_o), .req_o(req_o), .cnt_q(cnt_q)
);

// File: tb/tb_tx_sel_top.sv
module tb_tx_sel_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0, cfg_ext_i = 0, req_set_i = 0, cnt_we_i = 0;
  logic [3:0]  cfg_box_i = 0, req_box_i = 0;
  logic [28:0] cfg_id_i = 0;
  logic [4:0]  cnt_i = 0;
  logic        start_i = 0, done_ok_i = 0, done_err_i = 0;
  logic        sel_valid_o, busy_o;
  logic [3:0]  sel_box_o, last_box_o;
  logic [N-1:0] req_o;

  int vectors = 0, misses = 0, cycles = 0;

  tx_sel_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    cfg_we_i = 0; req_set_i = 0; cnt_we_i = 0;
    start_i = 0; done_ok_i = 0; done_err_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
  endtask

  task automatic wr_box(int b, int id, bit ext);
    cfg_we_i = 1; cfg_box_i = 4'(b); cfg_id_i = 29'(id); cfg_ext_i = ext; tick();
  endtask
  task automatic set_req(int b);
    req_set_i = 1; req_box_i = 4'(b); tick();
  endtask
  task automatic set_cnt(int c);
    cnt_we_i = 1; cnt_i = 5'(c); tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sel_valid", sel_valid_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 last_box", last_box_o, 0);
    chk("R1 req", req_o, 0);
    set_req(0);
    chk("R1 count zero blocks box0", sel_valid_o, 0);
  endtask

  task automatic t_count();
    do_reset();
    set_cnt(4);
    wr_box(8, 'h001, 0); set_req(8);
    chk("R10 req8", req_o, 16'h0100);
    chk("R2 box8 outside count", sel_valid_o, 0);
    wr_box(2, 'h1234567, 1); set_req(2);
    chk("R2 box2 inside count", sel_box_o, 2);
    chk("R2 valid", sel_valid_o, 1);
    set_cnt(16);
    chk("R2 count raised box8 wins", sel_box_o, 8);
    set_cnt(9);
    chk("R2 count 9 boundary", sel_box_o, 8);
    set_cnt(8);
    chk("R2 count 8 boundary", sel_box_o, 2);
  endtask

  task automatic t_prio();
    do_reset(); set_cnt(16);
    wr_box(3, 'h400, 0); wr_box(12, 'h3ff, 0);
    set_req(3); set_req(12);
    chk("R3 lower std id wins", sel_box_o, 12);
    wr_box(5, 'h0000001, 1); set_req(5);
    chk("R3 small ext beats std", sel_box_o, 5);
    wr_box(14, 'h0000000, 1); set_req(14);
    chk("R3 ext zero wins", sel_box_o, 14);
  endtask

  task automatic t_std_ext();
    do_reset(); set_cnt(16);
    wr_box(3, 'h0080000, 1); wr_box(7, 'h002, 0);
    set_req(3); set_req(7);
    chk("R4 std beats ext equal prefix", sel_box_o, 7);
  endtask

  task automatic t_tie();
    do_reset(); set_cnt(16);
    wr_box(6, 'h123, 0); wr_box(4, 'h123, 0);
    set_req(6);
    chk("R5 single", sel_box_o, 6);
    set_req(4);
    chk("R5 tie lower box", sel_box_o, 4);
    wr_box(11, 'h55, 1); wr_box(10, 'h55, 1);
    set_req(11); set_req(10);
    chk("R5 ext tie lower box", sel_box_o, 10);
  endtask

  task automatic t_lock();
    do_reset(); set_cnt(16);
    wr_box(1, 'h200, 0); wr_box(0, 'h001, 0);
    set_req(1);
    start_i = 1; tick();
    chk("R6 busy", busy_o, 1);
    chk("R6 locked box1", sel_box_o, 1);
    set_req(0);
    chk("R6 lock holds over new winner", sel_box_o, 1);
    done_ok_i = 1; done_err_i = 1; tick();
    chk("R7 busy cleared", busy_o, 0);
    chk("R7 req cleared", req_o, 16'h0001);
    chk("R7 last_box", last_box_o, 1);
    chk("R7 next offer", sel_box_o, 0);
    start_i = 1; tick();
    done_err_i = 1; tick();
    chk("R8 busy cleared", busy_o, 0);
    chk("R8 req kept", req_o, 16'h0001);
    chk("R8 reoffered", sel_box_o, 0);
    chk("R8 last_box unchanged", last_box_o, 1);
  endtask

  task automatic t_locked_write();
    do_reset(); set_cnt(16);
    wr_box(1, 'h200, 0); wr_box(2, 'h100, 0);
    set_req(1);
    start_i = 1; tick();
    wr_box(1, 'h000, 0);
    wr_box(3, 'h050, 0);
    done_err_i = 1; tick();
    set_req(2);
    chk("R9 locked write ignored", sel_box_o, 2);
    set_req(3);
    chk("R9 unlocked write taken", sel_box_o, 3);
  endtask

  task automatic t_idle();
    do_reset(); set_cnt(16);
    start_i = 1; tick();
    chk("R11 start with no offer", busy_o, 0);
    wr_box(9, 'h10, 0); set_req(9);
    done_ok_i = 1; tick();
    chk("R11 idle done keeps req", req_o, 16'h0200);
    chk("R11 idle done keeps last", last_box_o, 0);
    start_i = 1; tick();
    start_i = 1; wr_box(9, 'h0, 0);
    chk("R11 second start ignored", sel_box_o, 9);
    done_ok_i = 1; tick();
    chk("R7 done after start", last_box_o, 9);
    chk("R10 req cleared", req_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        misses++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_count();
    t_prio();
    t_std_ext();
    t_tie();
    t_lock();
    t_locked_write();
    t_idle();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule